// File: doc/BRIEF.md
# Structured-Light Pattern Exposure Sequencer

This block schedules the exposure of up to three 8-bit monochrome patterns carried in one 24-bit input frame. A rising edge on the frame sync input starts a train of identical pattern slots. Each slot has three phases in a fixed order: a dark lead-in, an exposure window with one light source lit, and a dark tail. The block drives three light-source enables and a slot index that selects the byte lane holding the current pattern. It also drives two trigger outputs for a camera or other observer: a frame trigger placed relative to the sync edge, and a pattern trigger placed relative to the start of each slot.

All settings arrive on static inputs and are captured only on the sync edge. The settings are the phase lengths in clock ticks, the slot count, a light-source code for each slot, and the trigger delays and width. Once the last slot has finished, the block stays dark until the next sync edge. A sync edge that arrives while a train is still running cuts that train short, sets a sticky overrun flag and starts again from slot 0. A setting that would give no exposure raises a configuration-error flag, and no slot runs in that frame.

Top module: `pseq_top`

## Requirements
- R1: Cycle 0 is the clock cycle that follows the edge at which `vsync` is first sampled high after being low. From cycle 0, `busy` is high for exactly n·L cycles, where n is `cfg_count` (1 to 3) and L = pre + exp + post are the tick counts captured at that edge.
- R2: Within slot k, which covers cycles k·L to k·L+L-1, a light source is lit only in the cycles from k·L+pre to k·L+pre+exp-1. In the dark lead-in and the dark tail all enables are low.
- R3: The light-source code for slot k sits in `cfg_led[2k+1:2k]`. Code 0 selects red, 1 selects green, 2 selects blue and 3 selects none. At most one enable is high in any cycle.
- R4: `slot_sel` equals k throughout slot k and is 0 while `busy` is low.
- R5: A pre or post length of zero removes that phase entirely and adds no cycle. The slot length is still pre + exp + post.
- R6: `frame_trig` is high in cycles `cfg_fdly` to `cfg_fdly`+`cfg_fwid`-1, counted from cycle 0 of the latest sync edge.
- R7: `pat_trig` is high in the cycles of each slot whose offset o from the slot start satisfies `cfg_pdly` ≤ o < `cfg_pdly`+exp. The pulse is cut off at the slot end and never appears outside `busy`.
- R8: After the last slot, all enables, `pat_trig` and `busy` stay low until the next sync edge.
- R9: Changing any configuration input after the sync edge has no effect on the frame in progress.
- R10: A sync edge that arrives while `busy` is high restarts the train from slot 0 with the new settings. It also sets `overrun`, which stays high until reset.
- R11: A sync edge that captures `cfg_count` = 0 or exp = 0 sets `cfg_err` and starts no slot. The frame trigger still runs. The next valid sync edge clears `cfg_err`.
- R12: While reset is held and just after it, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync | input | 1 | Frame sync; its rising edge starts a frame |
| cfg_count | input | 2 | Number of pattern slots, 1 to 3 |
| cfg_pre | input | TW | Dark lead-in length in ticks |
| cfg_exp | input | TW | Exposure length in ticks |
| cfg_post | input | TW | Dark tail length in ticks |
| cfg_led | input | 6 | Light-source code for each slot, 2 bits per slot |
| cfg_fdly | input | TW | Frame trigger delay from the sync edge |
| cfg_fwid | input | TW | Frame trigger width in ticks |
| cfg_pdly | input | TW | Pattern trigger delay from the slot start |
| led_r | output | 1 | Red source enable |
| led_g | output | 1 | Green source enable |
| led_b | output | 1 | Blue source enable |
| slot_sel | output | 2 | Current slot, which selects the byte lane |
| frame_trig | output | 1 | Frame trigger, active high |
| pat_trig | output | 1 | Pattern trigger, active high |
| busy | output | 1 | A slot train is running |
| overrun | output | 1 | Sticky: a sync edge arrived while busy |
| cfg_err | output | 1 | The last captured setting was invalid |

## Verification
A phase counter that is off by one shifts every later light-source window and slot boundary by one cycle. This shows within the same frame as a mismatch on the enables or on `slot_sel`, at the first phase change after the fault. A slot index that goes wrong lights the wrong colour or drives the wrong lane as soon as the next slot begins, and a faulty end-of-train decision leaves `busy` or an enable high into the dark remainder. The bench compares every output in every cycle of each frame against arithmetic expectations, so any of these faults is seen at most one slot after it occurs.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
    localparam int MAX_SLOTS = 3;
    localparam int SLOT_W    = 2;
    localparam int CODE_W    = 2;
    localparam int LEDCFG_W  = CODE_W * MAX_SLOTS;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_EXP  = 2'd2,
        PH_POST = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        SRC_RED   = 2'd0,
        SRC_GREEN = 2'd1,
        SRC_BLUE  = 2'd2,
        SRC_NONE  = 2'd3
    } src_code_e;

    typedef struct packed {
        logic b;
        logic g;
        logic r;
    } rgb_t;

    function automatic rgb_t src_decode(logic [CODE_W-1:0] code);
        rgb_t v;
        v = '0;
        case (src_code_e'(code))
            SRC_RED:   v.r = 1'b1;
            SRC_GREEN: v.g = 1'b1;
            SRC_BLUE:  v.b = 1'b1;
            default:   v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/pseq_frame_trig.sv
module pseq_frame_trig #(
    parameter int TW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [TW-1:0] dly,
    input  logic [TW-1:0] wid,
    output logic          trig
);
    localparam int CW = TW + 1;

    logic [CW-1:0] cnt;
    logic          active;
    logic [CW-1:0] stop_at;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (start) begin
            cnt    <= '0;
            active <= 1'b1;
        end else if (active && cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign stop_at = {1'b0, dly} + {1'b0, wid};
    assign trig    = active && (cnt >= {1'b0, dly}) && (cnt < stop_at);
endmodule

// File: rtl/pseq_slot_fsm.sv
module pseq_slot_fsm
    import pseq_pkg::*;
#(
    parameter int TW = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_ok,
    input  logic [TW-1:0]     len_pre,
    input  logic [TW-1:0]     len_exp,
    input  logic [TW-1:0]     len_post,
    input  logic [SLOT_W-1:0] n_slots,
    output phase_e            phase,
    output logic [SLOT_W-1:0] slot,
    output logic [TW+1:0]     offs
);
    phase_e            nph;
    logic [TW-1:0]     cnt, ncnt;
    logic [SLOT_W-1:0] nslot;
    logic              enter, slot_end;

    always_comb begin
        nph      = phase;
        nslot    = slot;
        ncnt     = (cnt != '0) ? cnt - 1'b1 : '0;
        enter    = 1'b0;
        slot_end = 1'b0;
        if (start) begin
            if (start_ok) begin
                enter = 1'b1;
                nslot = '0;
            end else begin
                nph   = PH_IDLE;
                nslot = '0;
                ncnt  = '0;
            end
        end else begin
            case (phase)
                PH_PRE: if (cnt == '0) begin
                    nph  = PH_EXP;
                    ncnt = len_exp - 1'b1;
                end
                PH_EXP: if (cnt == '0) begin
                    if (len_post != '0) begin
                        nph  = PH_POST;
                        ncnt = len_post - 1'b1;
                    end else begin
                        slot_end = 1'b1;
                    end
                end
                PH_POST: if (cnt == '0) slot_end = 1'b1;
                default: ;
            endcase
            if (slot_end) begin
                if (slot == n_slots - 1'b1) begin
                    nph   = PH_IDLE;
                    nslot = '0;
                    ncnt  = '0;
                end else begin
                    enter = 1'b1;
                    nslot = slot + 1'b1;
                end
            end
        end
        if (enter) begin
            if (len_pre != '0) begin
                nph  = PH_PRE;
                ncnt = len_pre - 1'b1;
            end else begin
                nph  = PH_EXP;
                ncnt = len_exp - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            slot  <= '0;
            cnt   <= '0;
            offs  <= '0;
        end else begin
            phase <= nph;
            slot  <= nslot;
            cnt   <= ncnt;
            if (enter)
                offs <= '0;
            else if (offs != '1)
                offs <= offs + 1'b1;
        end
    end
endmodule

// File: rtl/pseq_top.sv
module pseq_top
    import pseq_pkg::*;
#(
    parameter int TW = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vsync,
    input  logic [SLOT_W-1:0]   cfg_count,
    input  logic [TW-1:0]       cfg_pre,
    input  logic [TW-1:0]       cfg_exp,
    input  logic [TW-1:0]       cfg_post,
    input  logic [LEDCFG_W-1:0] cfg_led,
    input  logic [TW-1:0]       cfg_fdly,
    input  logic [TW-1:0]       cfg_fwid,
    input  logic [TW-1:0]       cfg_pdly,
    output logic                led_r,
    output logic                led_g,
    output logic                led_b,
    output logic [SLOT_W-1:0]   slot_sel,
    output logic                frame_trig,
    output logic                pat_trig,
    output logic                busy,
    output logic                overrun,
    output logic                cfg_err
);
    logic                vs_d, vs_rise, cfg_ok;
    logic [TW-1:0]       pre_q, exp_q, post_q, fdly_q, fwid_q, pdly_q;
    logic [TW-1:0]       pre_e, exp_e, post_e;
    logic [SLOT_W-1:0]   n_q, n_e;
    logic [LEDCFG_W-1:0] led_q;
    phase_e              phase;
    logic [SLOT_W-1:0]   slot;
    logic [TW+1:0]       offs;
    rgb_t                slot_rgb [MAX_SLOTS];
    rgb_t                cur_rgb;

    assign vs_rise = vsync && !vs_d;
    assign cfg_ok  = (cfg_count != '0) && (cfg_exp != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_d    <= 1'b0;
            pre_q   <= '0;
            exp_q   <= '0;
            post_q  <= '0;
            n_q     <= '0;
            led_q   <= '0;
            fdly_q  <= '0;
            fwid_q  <= '0;
            pdly_q  <= '0;
            overrun <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            vs_d <= vsync;
            if (vs_rise) begin
                pre_q   <= cfg_pre;
                exp_q   <= cfg_exp;
                post_q  <= cfg_post;
                n_q     <= cfg_count;
                led_q   <= cfg_led;
                fdly_q  <= cfg_fdly;
                fwid_q  <= cfg_fwid;
                pdly_q  <= cfg_pdly;
                cfg_err <= !cfg_ok;
                if (busy) overrun <= 1'b1;
            end
        end
    end

    assign pre_e  = vs_rise ? cfg_pre   : pre_q;
    assign exp_e  = vs_rise ? cfg_exp   : exp_q;
    assign post_e = vs_rise ? cfg_post  : post_q;
    assign n_e    = vs_rise ? cfg_count : n_q;

    pseq_slot_fsm #(.TW(TW)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (vs_rise),
        .start_ok (cfg_ok),
        .len_pre  (pre_e),
        .len_exp  (exp_e),
        .len_post (post_e),
        .n_slots  (n_e),
        .phase    (phase),
        .slot     (slot),
        .offs     (offs)
    );

    pseq_frame_trig #(.TW(TW)) u_ftrig (
        .clk   (clk),
        .rst   (rst),
        .start (vs_rise),
        .dly   (fdly_q),
        .wid   (fwid_q),
        .trig  (frame_trig)
    );

    for (genvar g = 0; g < MAX_SLOTS; g++) begin : g_slot_src
        assign slot_rgb[g] = src_decode(led_q[CODE_W*g +: CODE_W]);
    end

    always_comb begin
        cur_rgb = '0;
        for (int i = 0; i < MAX_SLOTS; i++)
            if (slot == SLOT_W'(i)) cur_rgb = slot_rgb[i];
    end

    assign busy     = (phase != PH_IDLE);
    assign slot_sel = slot;
    assign led_r    = (phase == PH_EXP) && cur_rgb.r;
    assign led_g    = (phase == PH_EXP) && cur_rgb.g;
    assign led_b    = (phase == PH_EXP) && cur_rgb.b;
    assign pat_trig = busy && (offs >= {2'b00, pdly_q})
                    && (offs < ({2'b00, pdly_q} + {2'b00, exp_q}));
endmodule

// File: rtl/pseq_chk.sv
module pseq_chk #(
    parameter int TW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          vsync,
    input logic [1:0]    cfg_count,
    input logic [TW-1:0] cfg_exp,
    input logic          led_r,
    input logic          led_g,
    input logic          led_b,
    input logic [1:0]    slot_sel,
    input logic          pat_trig,
    input logic          busy,
    input logic          overrun,
    input logic          cfg_err
);
    assert_start_R1: assert property (@(posedge clk) disable iff (rst)
        ($rose(vsync) && cfg_count != 2'd0 && cfg_exp != '0) |=> busy);

    assert_led_in_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (led_r || led_g || led_b) |-> busy);

    assert_one_source_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({led_r, led_g, led_b}));

    assert_slot_range_R4: assert property (@(posedge clk) disable iff (rst)
        slot_sel != 2'd3);

    assert_idle_slot_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> slot_sel == 2'd0);

    assert_ptrig_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
        pat_trig |-> busy);

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    assert_err_idle_R11: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !busy);

    assert_bad_cfg_R11: assert property (@(posedge clk) disable iff (rst)
        ($rose(vsync) && (cfg_count == 2'd0 || cfg_exp == '0)) |=> (cfg_err && !busy));
endmodule

bind pseq_top pseq_chk #(.TW(TW)) u_chk (.*);

// File: tb/sim_pseq_top.sv
module sim_pseq_top;
    localparam int TW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          vsync = 1'b0;
    logic [1:0]    cfg_count = '0;
    logic [TW-1:0] cfg_pre = '0, cfg_exp = '0, cfg_post = '0;
    logic [5:0]    cfg_led = '0;
    logic [TW-1:0] cfg_fdly = '0, cfg_fwid = '0, cfg_pdly = '0;
    logic          led_r, led_g, led_b, frame_trig, pat_trig, busy, overrun, cfg_err;
    logic [1:0]    slot_sel;

    int n_chk = 0;
    int n_err = 0;
    bit ovr_exp = 1'b0;

    always #5 clk = ~clk;

    pseq_top #(.TW(TW)) u0 (
        .clk(clk), .rst(rst), .vsync(vsync), .cfg_count(cfg_count),
        .cfg_pre(cfg_pre), .cfg_exp(cfg_exp), .cfg_post(cfg_post),
        .cfg_led(cfg_led), .cfg_fdly(cfg_fdly), .cfg_fwid(cfg_fwid),
        .cfg_pdly(cfg_pdly), .led_r(led_r), .led_g(led_g), .led_b(led_b),
        .slot_sel(slot_sel), .frame_trig(frame_trig), .pat_trig(pat_trig),
        .busy(busy), .overrun(overrun), .cfg_err(cfg_err)
    );

    task automatic chk(string tag, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic frame(int pre, int ex, int post, int n, int led,
                         int fdly, int fwid, int pdly, int ncyc, bit chg);
        int  len, tot, t_end;
        bit  ok;
        string tg;
        len = pre + ex + post;
        ok  = (n != 0) && (ex != 0);
        tot = ok ? n * len : 0;
        t_end = (tot > fdly + fwid) ? tot + 3 : fdly + fwid + 3;
        if (ncyc > 0) t_end = ncyc;
        @(negedge clk);
        cfg_pre = TW'(pre); cfg_exp = TW'(ex); cfg_post = TW'(post);
        cfg_count = 2'(n); cfg_led = 6'(led);
        cfg_fdly = TW'(fdly); cfg_fwid = TW'(fwid); cfg_pdly = TW'(pdly);
        vsync = 1'b1;
        for (int j = 0; j < t_end; j++) begin
            int k, o, code, e_led, e_sel, e_pt;
            bit b;
            @(negedge clk);
            if (j == 0) vsync = 1'b0;
            b = ok && (j < tot);
            k = b ? j / len : 0;
            o = b ? j % len : 0;
            code = (led >> (2 * k)) & 3;
            e_led = (b && o >= pre && o < pre + ex && code != 3) ? (1 << code) : 0;
            e_sel = k;
            e_pt  = (b && o >= pdly && o < pdly + ex) ? 1 : 0;
            tg = $sformatf("%s%s%s", (j >= tot) ? "R8 " : "",
                           (pre == 0 || post == 0) ? "R5 " : "", chg ? "R9 " : "");
            chk({tg, "R1 busy"}, int'(busy), int'(b));
            chk({tg, "R2 R3 leds"}, int'({led_b, led_g, led_r}), e_led);
            chk({tg, "R4 slot_sel"}, int'(slot_sel), e_sel);
            chk({tg, "R6 frame_trig"}, int'(frame_trig),
                (j >= fdly && j < fdly + fwid) ? 1 : 0);
            chk({tg, "R7 pat_trig"}, int'(pat_trig), e_pt);
            chk("R11 cfg_err", int'(cfg_err), ok ? 0 : 1);
            chk("R10 overrun", int'(overrun), int'(ovr_exp));
            if (chg && j == 0) begin
                cfg_pre = TW'(pre + 3); cfg_exp = TW'(ex + 2); cfg_post = TW'(post + 1);
                cfg_count = 2'd3; cfg_led = ~6'(led);
                cfg_fdly = TW'(fdly + 5); cfg_fwid = TW'(fwid + 4); cfg_pdly = TW'(pdly + 1);
            end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        vsync = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 reset busy", int'(busy), 0);
        chk("R12 reset outputs", int'({led_r, led_g, led_b, frame_trig, pat_trig,
                                       overrun, cfg_err, slot_sel}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 after reset", int'({busy, led_r, led_g, led_b, frame_trig, pat_trig,
                                     overrun, cfg_err, slot_sel}), 0);
    endtask

    initial begin
        int idx;
        do_reset();
        idx = 0;
        for (int n = 1; n <= 3; n++)
            for (int pi = 0; pi < 3; pi++)
                for (int ei = 1; ei <= 2; ei++)
                    for (int qi = 0; qi < 2; qi++) begin
                        int pre, post;
                        pre  = (pi == 2) ? 3 : pi;
                        post = 2 * qi;
                        frame(pre, ei, post, n, (idx * 7 + 9) % 64,
                              idx % 3, 1 + idx % 4, idx % 3, 0, 1'b0);
                        idx++;
                    end
        // R9: settings altered mid-frame must not change it
        frame(2, 3, 1, 3, 6'b10_01_00, 1, 2, 1, 0, 1'b1);
        frame(0, 2, 0, 2, 6'b11_10_01, 4, 3, 2, 0, 1'b1);
        // R11: invalid count, invalid exposure, then recovery
        frame(1, 2, 1, 0, 6'b00_00_00, 2, 3, 0, 0, 1'b0);
        frame(1, 0, 1, 2, 6'b00_00_00, 0, 2, 0, 0, 1'b0);
        frame(1, 2, 1, 1, 6'b00_00_10, 1, 1, 0, 0, 1'b0);
        // R10: restart while running
        frame(2, 3, 2, 3, 6'b10_01_00, 1, 3, 1, 6, 1'b0);
        ovr_exp = 1'b1;
        frame(1, 2, 1, 2, 6'b00_01_10, 0, 2, 0, 0, 1'b0);
        frame(0, 1, 0, 3, 6'b01_10_00, 2, 1, 0, 0, 1'b0);
        ovr_exp = 1'b0;
        do_reset();
        chk("R10 overrun cleared by reset", int'(overrun), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule